// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the front end of an instruction pipeline. It keeps a byte program counter, reads one 16-bit instruction word per cycle from a synchronous program memory, and hands execute one valid-qualified instruction at a time. Words sit little-endian in memory: the low byte is at the even address and the high byte at the odd one. The counter therefore moves in steps of two, and its bit 0 is always zero.

Four opcode groups need a second word: register-to-register move, call, goto and load-pointer. The sequencer holds such a first word and waits for the next one. It then issues both as a single instruction, with the low 12 bits of the second word attached as extension data. Every second word starts with the nibble 1111. If such a word turns up without its first word, for example because execute skipped the first word, it issues as a no-operation. For call and goto the sequencer also puts together the absolute byte target.

Execute drives the control flow. A skip request drops the next first word. An absolute jump takes a word address. A taken relative branch gives a signed offset counted in words. A jump or a branch throws away every word still in flight.

Top module: `fetch_seq`

## Requirements
- R1: While `rstN` is low, `issueValid` is 0 and `memAddr` is 0.
- R2: Without a redirect, `memAddr` rises by 2 every cycle and bit 0 stays 0. Words issue in address order, and `issuePc` holds the byte address of the instruction's first word.
- R3: A word is single-word when it is not a second word and its top nibble is not 1111. Such a word issues with `issueTwoWord`=0, `issueNop`=0, `issueAbs`=0 and `issueExt`=0.
- R4: A first word with top nibble 1100 (move), top byte 0xEC or 0xED (call), 0xEF (goto) or 0xEE (load-pointer) is joined with the next word. The pair issues once, with `issueWord` set to the first word, `issueExt` set to the second word's bits 11:0, `issueTwoWord`=1 and `issuePc` set to the first word's address.
- R5: A word with top nibble 1111 that arrives where a first word is expected issues with `issueNop`=1 and `issueTwoWord`=0.
- R6: A skip request drops the next word that would start an instruction. If that word opens a two-word instruction, its second word then issues as a no-operation (R5).
- R7: For call and goto, `issueAbs`=1 and `issueJumpTgt` = {ext[11:0], first[7:0], 0}. Example: goto EF03h/F000h gives 000006h.
- R8: When `jumpValid` is high at an edge, `memAddr` becomes {`jumpWordAddr`, 0} on the next cycle. Every word fetched before then is discarded, and the next issued instruction is the one at the target.
- R9: When `brValid` is high at an edge, the fetch restarts at the address following the last issued instruction plus twice the sign-extended 11-bit `brOffset`. Words in flight are discarded.
- R10: If a jump and a skip come in the same cycle, the jump wins and the skip is discarded. If a jump and a branch come in the same cycle, the jump target is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 21 | Byte address of the word being fetched |
| memData | input | 16 | Word read from memory, one cycle after its address |
| skipReq | input | 1 | Skip the next instruction-starting word |
| jumpValid | input | 1 | Absolute redirect strobe |
| jumpWordAddr | input | 20 | Absolute target as a word address |
| brValid | input | 1 | Taken relative branch strobe |
| brOffset | input | 11 | Signed branch offset in words |
| issueValid | output | 1 | Issued instruction is valid |
| issuePc | output | 21 | Byte address of the issued instruction |
| issueWord | output | 16 | First (or only) word |
| issueExt | output | 12 | Second word data, zero for single-word |
| issueTwoWord | output | 1 | Instruction was joined from two words |
| issueNop | output | 1 | Lone second word, run as no-operation |
| issueAbs | output | 1 | Instruction is a call or goto |
| issueJumpTgt | output | 21 | Byte target of call or goto |

## Verification
The case to watch is a skip and a redirect landing on the same edge. A word that opens a two-word instruction is in the data stage, and both the skip and the jump want to act on it. The bench raises `skipReq` and `jumpValid` together right after an issue. It then expects the two-word instruction at the jump target to issue whole. A skip that survived the flush would drop that word and turn up as a lone no-operation. In a second case a branch and a jump are raised together, and the bench expects the jump target's instruction to issue.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int WORD_W = 16;
  localparam int EXT_W  = 12;

  typedef enum logic {
    ST_FIRST  = 1'b0,
    ST_SECOND = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic redirect;     // load a new PC, kill words in flight
    logic useJump;      // absolute target selected (else relative)
    logic holdFirst;    // latch an opening word of a pair
    logic issueSingle;  // issue the current word alone
    logic issueJoin;    // issue held word plus current word
    logic markNop;      // single issue is a lone continuation word
  } seqStrobe_t;

  function automatic logic isContinuation(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: 4] == 4'hF;
  endfunction

  function automatic logic isAbsJump(input logic [WORD_W-1:0] w);
    return (w[15:9] == 7'b1110110) || (w[15:8] == 8'hEF);
  endfunction

  function automatic logic isTwoWord(input logic [WORD_W-1:0] w);
    return (w[15:12] == 4'hC) || isAbsJump(w) || (w[15:8] == 8'hEE);
  endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              skipReq,
  input  logic              jumpValid,
  input  logic              brValid,
  output seqStrobe_t        strobe
);

  seqState_t state, stateNext;
  logic      skipPend, skipPendNext;
  logic      skipEff, redirect;

  always_comb begin
    redirect     = jumpValid | brValid;
    skipEff      = skipPend | skipReq;
    strobe       = '0;
    strobe.redirect = redirect;
    strobe.useJump  = jumpValid;
    stateNext    = state;
    skipPendNext = skipEff;
    if (redirect) begin
      // a redirect discards everything, including a pending skip
      stateNext    = ST_FIRST;
      skipPendNext = 1'b0;
    end else if (fetchValid) begin
      if (state == ST_SECOND) begin
        strobe.issueJoin = 1'b1;
        stateNext        = ST_FIRST;
      end else if (skipEff) begin
        skipPendNext = 1'b0;          // this word is dropped
      end else if (isTwoWord(fetchWord)) begin
        strobe.holdFirst = 1'b1;
        stateNext        = ST_SECOND;
      end else begin
        strobe.issueSingle = 1'b1;
        strobe.markNop     = isContinuation(fetchWord);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_FIRST;
      skipPend <= 1'b0;
    end else begin
      state    <= stateNext;
      skipPend <= skipPendNext;
    end
  end

  // R6: a consumed skip leaves nothing pending behind it
  a_r6_skip_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && state == ST_FIRST && skipEff && !redirect) |=> !skipPend);

  // R10: a redirect always returns to the first-word state with no skip
  a_r10_redirect_clears: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (state == ST_FIRST && !skipPend));

  // R4: the second-word state lasts at most one valid word
  a_r4_pair_closes: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SECOND && fetchValid) |=> state == ST_FIRST);

endmodule

// File: rtl/fseq_dpath.sv
module fseq_dpath
  import fseq_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [WORD_W-1:0] memData,
  input  logic [PC_W-2:0]   jumpWordAddr,
  input  logic [OFF_W-1:0]  brOffset,
  output logic [PC_W-1:0]   memAddr,
  output logic              fetchValid,
  output logic              issueValid,
  output logic [PC_W-1:0]   issuePc,
  output logic [WORD_W-1:0] issueWord,
  output logic [EXT_W-1:0]  issueExt,
  output logic              issueTwoWord,
  output logic              issueNop,
  output logic              issueAbs,
  output logic [PC_W-1:0]   issueJumpTgt
);

  localparam logic [PC_W-1:0] STEP  = PC_W'(2);
  localparam int              SXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0]   pc, fetchPc, holdPc, lastNext;
  logic [WORD_W-1:0] holdWord;
  logic [PC_W-1:0]   brStep, redirTarget, joinTgt;

  assign memAddr = pc;
  assign brStep  = {{SXT_W{brOffset[OFF_W-1]}}, brOffset, 1'b0};
  assign redirTarget = strobe.useJump ? {jumpWordAddr, 1'b0} : (lastNext + brStep);
  assign joinTgt = PC_W'({memData[EXT_W-1:0], holdWord[7:0], 1'b0});

  // fetch side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc         <= '0;
      fetchPc    <= '0;
      fetchValid <= 1'b0;
    end else if (strobe.redirect) begin
      pc         <= redirTarget;
      fetchValid <= 1'b0;
    end else begin
      pc         <= pc + STEP;
      fetchPc    <= pc;
      fetchValid <= 1'b1;
    end
  end

  // pair holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      holdPc   <= '0;
    end else if (strobe.holdFirst) begin
      holdWord <= memData;
      holdPc   <= fetchPc;
    end
  end

  // issue side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueValid   <= 1'b0;
      issuePc      <= '0;
      issueWord    <= '0;
      issueExt     <= '0;
      issueTwoWord <= 1'b0;
      issueNop     <= 1'b0;
      issueAbs     <= 1'b0;
      issueJumpTgt <= '0;
      lastNext     <= '0;
    end else begin
      issueValid <= strobe.issueSingle | strobe.issueJoin;
      if (strobe.issueSingle) begin
        issuePc      <= fetchPc;
        issueWord    <= memData;
        issueExt     <= '0;
        issueTwoWord <= 1'b0;
        issueNop     <= strobe.markNop;
        issueAbs     <= 1'b0;
        issueJumpTgt <= '0;
        lastNext     <= fetchPc + STEP;
      end else if (strobe.issueJoin) begin
        issuePc      <= holdPc;
        issueWord    <= holdWord;
        issueExt     <= memData[EXT_W-1:0];
        issueTwoWord <= 1'b1;
        issueNop     <= 1'b0;
        issueAbs     <= isAbsJump(holdWord);
        issueJumpTgt <= isAbsJump(holdWord) ? joinTgt : '0;
        lastNext     <= fetchPc + STEP;
      end
    end
  end

  // R2: sequential fetch advances one word per cycle
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.redirect |=> memAddr == $past(memAddr) + STEP);

  // R2: byte address stays word aligned
  a_r2_pc_even: assert property (@(posedge clk) disable iff (!rstN)
    !memAddr[0]);

  // R8: a redirect kills the word in flight and the next issue slot
  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    strobe.redirect |=> (!issueValid && !fetchValid));

  // R5: a no-operation issue is a lone continuation word
  a_r5_nop_shape: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueNop) |-> (issueWord[15:12] == 4'hF && !issueTwoWord && issueExt == '0));

  // R4: a joined instruction spans two words for the next-address base
  a_r4_join_span: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueTwoWord) |-> lastNext == issuePc + STEP + STEP);

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PC_W-1:0]   memAddr,
  input  logic [WORD_W-1:0] memData,
  input  logic              skipReq,
  input  logic              jumpValid,
  input  logic [PC_W-2:0]   jumpWordAddr,
  input  logic              brValid,
  input  logic [OFF_W-1:0]  brOffset,
  output logic              issueValid,
  output logic [PC_W-1:0]   issuePc,
  output logic [WORD_W-1:0] issueWord,
  output logic [EXT_W-1:0]  issueExt,
  output logic              issueTwoWord,
  output logic              issueNop,
  output logic              issueAbs,
  output logic [PC_W-1:0]   issueJumpTgt
);

  seqStrobe_t strobe;
  logic       fetchValid;

  fseq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fetchWord  (memData),
    .skipReq    (skipReq),
    .jumpValid  (jumpValid),
    .brValid    (brValid),
    .strobe     (strobe)
  );

  fseq_dpath #(.PC_W(PC_W), .OFF_W(OFF_W)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .memData      (memData),
    .jumpWordAddr (jumpWordAddr),
    .brOffset     (brOffset),
    .memAddr      (memAddr),
    .fetchValid   (fetchValid),
    .issueValid   (issueValid),
    .issuePc      (issuePc),
    .issueWord    (issueWord),
    .issueExt     (issueExt),
    .issueTwoWord (issueTwoWord),
    .issueNop     (issueNop),
    .issueAbs     (issueAbs),
    .issueJumpTgt (issueJumpTgt)
  );

  // R1: nothing issues straight out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !issueValid);

  // R10: with a jump present the fetch goes to the absolute target
  a_r10_jump_wins: assert property (@(posedge clk) disable iff (!rstN)
    jumpValid |=> memAddr == {$past(jumpWordAddr), 1'b0});

endmodule

// File: tb/tb_fetch_seq.sv
`timescale 1ns/1ps
module tb_fetch_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic [20:0] memAddr;
  logic [15:0] memData;
  logic        skipReq, jumpValid, brValid;
  logic [19:0] jumpWordAddr;
  logic [10:0] brOffset;
  logic        issueValid, issueTwoWord, issueNop, issueAbs;
  logic [20:0] issuePc, issueJumpTgt;
  logic [15:0] issueWord;
  logic [11:0] issueExt;

  always #2.5 clk = ~clk;

  fetch_seq dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memData(memData),
    .skipReq(skipReq), .jumpValid(jumpValid), .jumpWordAddr(jumpWordAddr),
    .brValid(brValid), .brOffset(brOffset), .issueValid(issueValid),
    .issuePc(issuePc), .issueWord(issueWord), .issueExt(issueExt),
    .issueTwoWord(issueTwoWord), .issueNop(issueNop), .issueAbs(issueAbs),
    .issueJumpTgt(issueJumpTgt)
  );

  // synchronous program memory, 64 words
  logic [15:0] mem [0:63];
  always_ff @(posedge clk) memData <= mem[memAddr[6:1]];

  typedef struct {
    logic [20:0] pc;
    logic [15:0] word;
    logic [11:0] ext;
    logic        two, nop, abs;
    logic [20:0] tgt;
    int          react;   // 0 none, 1 jump, 2 branch, 3 skip, 4 jump+skip, 5 jump+branch
    logic [19:0] jwa;
    logic [10:0] off;
    string       tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  logic        addrChk = 1'b0;
  logic [20:0] addrExp;
  string       addrTag;

  task automatic pushItem(input logic [20:0] pc, input logic [15:0] word,
                          input logic [11:0] ext, input logic two, input logic nop,
                          input logic abs, input logic [20:0] tgt, input int react,
                          input logic [19:0] jwa, input logic [10:0] off, input string tag);
    item_t it;
    it.pc = pc; it.word = word; it.ext = ext; it.two = two; it.nop = nop;
    it.abs = abs; it.tgt = tgt; it.react = react; it.jwa = jwa; it.off = off; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares issues against the queue and plays the execute stage
  initial begin
    item_t it;
    skipReq = 1'b0; jumpValid = 1'b0; brValid = 1'b0;
    jumpWordAddr = '0; brOffset = '0;
    forever begin
      @(negedge clk);
      skipReq = 1'b0; jumpValid = 1'b0; brValid = 1'b0;
      if (addrChk) begin
        total++;
        if (memAddr !== addrExp) begin
          bad++;
          $display("FAIL %s redirect fetch address actual=%h expected=%h", addrTag, memAddr, addrExp);
        end
        addrChk = 1'b0;
      end
      if (rstN === 1'b1 && issueValid === 1'b1 && q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (issuePc !== it.pc || issueWord !== it.word || issueExt !== it.ext ||
            issueTwoWord !== it.two || issueNop !== it.nop || issueAbs !== it.abs ||
            issueJumpTgt !== it.tgt) begin
          bad++;
          $display("FAIL %s issue actual pc=%h w=%h ext=%h two=%b nop=%b abs=%b tgt=%h expected pc=%h w=%h ext=%h two=%b nop=%b abs=%b tgt=%h",
                   it.tag, issuePc, issueWord, issueExt, issueTwoWord, issueNop, issueAbs, issueJumpTgt,
                   it.pc, it.word, it.ext, it.two, it.nop, it.abs, it.tgt);
        end
        case (it.react)
          1, 4, 5: begin
            jumpValid = 1'b1; jumpWordAddr = it.jwa;
            skipReq   = (it.react == 4);
            brValid   = (it.react == 5); brOffset = it.off;
            addrChk = 1'b1; addrExp = {it.jwa, 1'b0};
            addrTag = (it.react == 1) ? "R8" : "R10";
          end
          2: begin
            brValid = 1'b1; brOffset = it.off;
            addrChk = 1'b1;
            addrExp = it.pc + 21'd2 + {{9{it.off[10]}}, it.off, 1'b0};
            addrTag = "R9";
          end
          3: skipReq = 1'b1;
          default: ;
        endcase
      end
    end
  end

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    total++;
    if (issueValid !== 1'b0 || memAddr !== 21'd0) begin
      bad++;
      $display("FAIL R1 reset state actual valid=%b addr=%h expected valid=0 addr=0", issueValid, memAddr);
    end
  endtask

  task automatic releaseAndDrain();
    @(negedge clk);
    rstN = 1'b1;
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 16'h2401;
    mem[6'h00] = 16'h0F55; mem[6'h01] = 16'hEF03; mem[6'h02] = 16'hF000;
    mem[6'h03] = 16'hC123; mem[6'h04] = 16'hF456; mem[6'h05] = 16'h6600;
    mem[6'h06] = 16'hC1AB; mem[6'h07] = 16'hF3CD; mem[6'h08] = 16'h2400;
    mem[6'h09] = 16'hD003; mem[6'h0D] = 16'hEC20; mem[6'h0E] = 16'hF000;
    mem[6'h1E] = 16'hEF30; mem[6'h1F] = 16'hF000; mem[6'h20] = 16'hEE01;
    mem[6'h21] = 16'hF234; mem[6'h22] = 16'h6600; mem[6'h23] = 16'h2402;
    mem[6'h24] = 16'h6601; mem[6'h25] = 16'hF777; mem[6'h26] = 16'hD7F7;
    mem[6'h30] = 16'h0000; mem[6'h31] = 16'hEF31; mem[6'h32] = 16'hF000;

    // phase 1: main stream with skips, jumps and branches
    holdReset();
    pushItem(21'h00, 16'h0F55, 12'h000, 0, 0, 0, 21'h00, 0, 0, 0, "R3");
    pushItem(21'h02, 16'hEF03, 12'h000, 1, 0, 1, 21'h06, 1, 20'h3, 0, "R7");
    pushItem(21'h06, 16'hC123, 12'h456, 1, 0, 0, 21'h00, 0, 0, 0, "R4");
    pushItem(21'h0A, 16'h6600, 12'h000, 0, 0, 0, 21'h00, 3, 0, 0, "R3");
    pushItem(21'h0E, 16'hF3CD, 12'h000, 0, 1, 0, 21'h00, 0, 0, 0, "R6");
    pushItem(21'h10, 16'h2400, 12'h000, 0, 0, 0, 21'h00, 0, 0, 0, "R2");
    pushItem(21'h12, 16'hD003, 12'h000, 0, 0, 0, 21'h00, 2, 0, 11'h003, "R2");
    pushItem(21'h1A, 16'hEC20, 12'h000, 1, 0, 1, 21'h40, 1, 20'h20, 0, "R9");
    pushItem(21'h40, 16'hEE01, 12'h234, 1, 0, 0, 21'h00, 0, 0, 0, "R4");
    pushItem(21'h44, 16'h6600, 12'h000, 0, 0, 0, 21'h00, 3, 0, 0, "R7");
    pushItem(21'h48, 16'h6601, 12'h000, 0, 0, 0, 21'h00, 0, 0, 0, "R6");
    pushItem(21'h4A, 16'hF777, 12'h000, 0, 1, 0, 21'h00, 0, 0, 0, "R5");
    pushItem(21'h4C, 16'hD7F7, 12'h000, 0, 0, 0, 21'h00, 2, 0, 11'h7F7, "R3");
    pushItem(21'h3C, 16'hEF30, 12'h000, 1, 0, 1, 21'h60, 1, 20'h30, 0, "R9");
    pushItem(21'h60, 16'h0000, 12'h000, 0, 0, 0, 21'h00, 0, 0, 0, "R8");
    pushItem(21'h62, 16'hEF31, 12'h000, 1, 0, 1, 21'h62, 1, 20'h31, 0, "R7");
    releaseAndDrain();

    // phase 2: skip and jump in the same cycle; pair at target must stay whole
    holdReset();
    pushItem(21'h00, 16'h0F55, 12'h000, 0, 0, 0, 21'h00, 4, 20'h20, 0, "R1");
    pushItem(21'h40, 16'hEE01, 12'h234, 1, 0, 0, 21'h00, 0, 0, 0, "R10");
    releaseAndDrain();

    // phase 3: branch and jump in the same cycle; jump target used
    holdReset();
    pushItem(21'h00, 16'h0F55, 12'h000, 0, 0, 0, 21'h00, 5, 20'h30, 11'h003, "R1");
    pushItem(21'h60, 16'h0000, 12'h000, 0, 0, 0, 21'h00, 0, 0, 0, "R10");
    releaseAndDrain();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired, pending items actual=%0d expected=0", q.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule